// File: doc/BRIEF.md
# Dual-Pointer Flat Data-Memory Mapper

This block decodes every data-memory access of a small microcontroller core. An access with an address in the instruction always goes to the special-function register (SFR) space, which lives outside the block. Two indirect ports each reach memory through their own pointer register, and in normal (flat) operation they address a private linear RAM that sits underneath the SFR map. A pointer in flat mode can never land on a peripheral register. Each indirect port can advance its pointer after the access. In flat mode the pointer wraps around the RAM size, so a block copy loop never has to test its bounds.

A single mode bit selects a compatibility decode. When it is set, each pointer is taken as an 8-bit address into the legacy register map. Legacy addresses below `SFR_SPAN` reach the SFR bus. Addresses at or above it reach the RAM entry with the same 8-bit index. The external SFR bus takes one request per cycle. The direct access has first claim, then indirect port 0, then indirect port 1. All accesses are single-cycle strobes with no back-pressure: every request is taken in the cycle it is presented, and a request that loses SFR arbitration is not retried. Reads are combinational. Writes and pointer and mode updates take effect at the rising clock edge.

Top module: `flatmem_mapper`

## Requirements
- R1: A synchronous reset clears both pointers to 0 and clears the mode bit, so the block leaves reset in flat mode.
- R2: A direct read or write always drives the SFR bus with `sfr_owner` = 1, `sfr_addr` = `dir_addr`, `sfr_wdata` = `dir_wdata` and the same strobes, in both modes. `dir_rdata` returns `sfr_rdata` when `dir_rd` is high and 0 otherwise.
- R3: In flat mode an indirect access never produces an SFR request. It addresses RAM entry `ptr_q[i]`.
- R4: An indirect RAM read returns the addressed entry combinationally. A RAM write commits at the clock edge, so a read of the same entry in the same cycle still sees the old value. `ind_rdata[i]` is 0 when `ind_rd[i]` is low.
- R5: In flat mode an access with `ind_inc[i]` high advances the pointer by one, modulo DEPTH (the last entry is followed by 0).
- R6: `ptr_ld[i]` loads `ptr_ld_val[i]` into pointer i at the next edge and overrides any increment in that cycle.
- R7: If both ports write the same RAM entry in one cycle, port 0's data is kept.
- R8: In compatibility mode, with a = `ptr_q[i][7:0]`, an access goes to the SFR bus at address a when a < SFR_SPAN, and otherwise to RAM entry a.
- R9: In compatibility mode the increment works on the low 8 bits only: the result is `ptr_q[7:0]+1` mod 256, and the upper pointer bits are cleared.
- R10: SFR bus priority is direct, then port 0, then port 1. `sfr_owner` encodes 0 = none, 1 = direct, 2 = port 0, 3 = port 1. A port that loses arbitration reads 0 and its write is dropped, but its pointer still steps. With no owner, `sfr_rd` and `sfr_wr` are low.
- R11: `mode_ld` loads `mode_val` into the mode bit (1 = compatibility) at the next edge. `compat_mode` shows the bit.
- R12: `ram_sel[i]` is high exactly when port i's access goes to RAM. `ram_we[i]` is high exactly when that access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dir_rd | input | 1 | Direct read strobe |
| dir_wr | input | 1 | Direct write strobe |
| dir_addr | input | 8 | Direct SFR address |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Direct read data |
| ind_rd | input | 2 | Indirect read strobe per port |
| ind_wr | input | 2 | Indirect write strobe per port |
| ind_inc | input | 2 | Post-increment request per port |
| ind_wdata | input | 2x8 | Indirect write data per port |
| ind_rdata | output | 2x8 | Indirect read data per port |
| ptr_ld | input | 2 | Pointer load strobe per port |
| ptr_ld_val | input | 2xAW | Pointer load value (AW = log2 DEPTH) |
| ptr_q | output | 2xAW | Current pointer values |
| mode_ld | input | 1 | Mode bit load strobe |
| mode_val | input | 1 | Mode value, 1 = compatibility |
| compat_mode | output | 1 | Current mode bit |
| sfr_rd | output | 1 | SFR bus read strobe |
| sfr_wr | output | 1 | SFR bus write strobe |
| sfr_addr | output | 8 | SFR bus address |
| sfr_wdata | output | 8 | SFR bus write data |
| sfr_rdata | input | 8 | SFR bus read data |
| sfr_owner | output | 2 | Current SFR bus owner |
| ram_sel | output | 2 | Port access goes to RAM |
| ram_we | output | 2 | Port writes RAM |

## Verification
The properties assume that every input is a known value in each cycle after reset, and that the strobes are only sampled at the rising edge. The properties on pointer steps also rely on an increment being requested only together with an access. The bench sets all inputs just after a rising edge and holds them for the whole cycle. It drives `ind_inc` only together with a read or write strobe, and it exercises a 512-entry array, so that modulo-512 wrapping and the 8-bit compatibility wrap give different results.

// File: rtl/flatmem_pkg.sv
package flatmem_pkg;

  typedef logic [7:0] fm_byte_t;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_DIR  = 2'd1,
    OWN_IND0 = 2'd2,
    OWN_IND1 = 2'd3
  } fm_owner_e;

endpackage

// File: rtl/fm_ptr_unit.sv
module fm_ptr_unit #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          compat,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  output logic [AW-1:0] ptr_q
);

  logic [7:0]    low_inc;
  logic [AW-1:0] ptr_d;

  assign low_inc = ptr_q[7:0] + 8'd1;

  always_comb begin
    ptr_d = ptr_q;
    if (ld) begin
      ptr_d = ld_val;
    end else if (step) begin
      if (compat) ptr_d = AW'(low_inc);
      else        ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_d;
  end

endmodule

// File: rtl/fm_ram_bank.sv
module fm_ram_bank #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic [1:0]           we,
  input  logic [1:0][AW-1:0]   addr,
  input  logic [1:0][7:0]      wdata,
  output logic [1:0][7:0]      rdata
);

  logic [7:0] mem [DEPTH];

  // port 1 first, port 0 last: port 0 wins a same-entry collision
  always_ff @(posedge clk) begin
    if (we[1]) mem[addr[1]] <= wdata[1];
    if (we[0]) mem[addr[0]] <= wdata[0];
  end

  for (genvar g = 0; g < 2; g++) begin : g_rd
    assign rdata[g] = mem[addr[g]];
  end

endmodule

// File: rtl/fm_sfr_arbiter.sv
module fm_sfr_arbiter
  import flatmem_pkg::*;
(
  input  logic            dir_rd,
  input  logic            dir_wr,
  input  fm_byte_t        dir_addr,
  input  fm_byte_t        dir_wdata,
  input  logic [1:0]      req,
  input  logic [1:0]      rd,
  input  logic [1:0]      wr,
  input  logic [1:0][7:0] addr,
  input  logic [1:0][7:0] wdata,
  output logic            sfr_rd,
  output logic            sfr_wr,
  output fm_byte_t        sfr_addr,
  output fm_byte_t        sfr_wdata,
  output fm_owner_e       owner
);

  always_comb begin
    sfr_rd    = 1'b0;
    sfr_wr    = 1'b0;
    sfr_addr  = '0;
    sfr_wdata = '0;
    owner     = OWN_NONE;
    if (dir_rd || dir_wr) begin
      owner     = OWN_DIR;
      sfr_rd    = dir_rd;
      sfr_wr    = dir_wr;
      sfr_addr  = dir_addr;
      sfr_wdata = dir_wdata;
    end else if (req[0]) begin
      owner     = OWN_IND0;
      sfr_rd    = rd[0];
      sfr_wr    = wr[0];
      sfr_addr  = addr[0];
      sfr_wdata = wdata[0];
    end else if (req[1]) begin
      owner     = OWN_IND1;
      sfr_rd    = rd[1];
      sfr_wr    = wr[1];
      sfr_addr  = addr[1];
      sfr_wdata = wdata[1];
    end
  end

endmodule

// File: rtl/flatmem_mapper.sv
module flatmem_mapper
  import flatmem_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int SFR_SPAN = 32,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dir_rd,
  input  logic                dir_wr,
  input  logic [7:0]          dir_addr,
  input  logic [7:0]          dir_wdata,
  output logic [7:0]          dir_rdata,
  input  logic [1:0]          ind_rd,
  input  logic [1:0]          ind_wr,
  input  logic [1:0]          ind_inc,
  input  logic [1:0][7:0]     ind_wdata,
  output logic [1:0][7:0]     ind_rdata,
  input  logic [1:0]          ptr_ld,
  input  logic [1:0][AW-1:0]  ptr_ld_val,
  output logic [1:0][AW-1:0]  ptr_q,
  input  logic                mode_ld,
  input  logic                mode_val,
  output logic                compat_mode,
  output logic                sfr_rd,
  output logic                sfr_wr,
  output logic [7:0]          sfr_addr,
  output logic [7:0]          sfr_wdata,
  input  logic [7:0]          sfr_rdata,
  output logic [1:0]          sfr_owner,
  output logic [1:0]          ram_sel,
  output logic [1:0]          ram_we
);

  localparam logic [8:0] SPAN9 = 9'(SFR_SPAN);

  logic [1:0]          acc;
  logic [1:0]          sfr_hit;
  logic [1:0]          sfr_req;
  logic [1:0][7:0]     leg_addr;
  logic [1:0][AW-1:0]  ram_idx;
  logic [1:0][7:0]     ram_rdata;
  fm_owner_e           owner;

  // mode bit of the bank-select register
  always_ff @(posedge clk) begin
    if (rst)          compat_mode <= 1'b0;
    else if (mode_ld) compat_mode <= mode_val;
  end

  for (genvar g = 0; g < 2; g++) begin : g_port
    localparam fm_owner_e MY_OWN = (g == 0) ? OWN_IND0 : OWN_IND1;

    assign acc[g]      = ind_rd[g] | ind_wr[g];
    assign leg_addr[g] = ptr_q[g][7:0];
    assign sfr_hit[g]  = compat_mode && ({1'b0, leg_addr[g]} < SPAN9);
    assign sfr_req[g]  = acc[g] & sfr_hit[g];
    assign ram_idx[g]  = compat_mode ? AW'(leg_addr[g]) : ptr_q[g];
    assign ram_sel[g]  = acc[g] & ~sfr_hit[g];
    assign ram_we[g]   = ind_wr[g] & ~sfr_hit[g];

    always_comb begin
      ind_rdata[g] = 8'h00;
      if (ind_rd[g]) begin
        if (!sfr_hit[g])          ind_rdata[g] = ram_rdata[g];
        else if (owner == MY_OWN) ind_rdata[g] = sfr_rdata;
      end
    end

    fm_ptr_unit #(.AW(AW)) u_ptr (
      .clk    (clk),
      .rst    (rst),
      .compat (compat_mode),
      .ld     (ptr_ld[g]),
      .ld_val (ptr_ld_val[g]),
      .step   (acc[g] & ind_inc[g]),
      .ptr_q  (ptr_q[g])
    );
  end

  fm_ram_bank #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_idx),
    .wdata (ind_wdata),
    .rdata (ram_rdata)
  );

  fm_sfr_arbiter u_arb (
    .dir_rd    (dir_rd),
    .dir_wr    (dir_wr),
    .dir_addr  (dir_addr),
    .dir_wdata (dir_wdata),
    .req       (sfr_req),
    .rd        (ind_rd),
    .wr        (ind_wr),
    .addr      (leg_addr),
    .wdata     (ind_wdata),
    .sfr_rd    (sfr_rd),
    .sfr_wr    (sfr_wr),
    .sfr_addr  (sfr_addr),
    .sfr_wdata (sfr_wdata),
    .owner     (owner)
  );

  assign sfr_owner = owner;
  assign dir_rdata = dir_rd ? sfr_rdata : 8'h00;

endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int DEPTH    = 256,
  parameter int SFR_SPAN = 32,
  localparam int AW      = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rst,
  input logic               dir_rd,
  input logic               dir_wr,
  input logic [7:0]         dir_addr,
  input logic [1:0]         ind_rd,
  input logic [1:0]         ind_wr,
  input logic [1:0]         ind_inc,
  input logic [1:0]         ptr_ld,
  input logic [1:0][AW-1:0] ptr_ld_val,
  input logic [1:0][AW-1:0] ptr_q,
  input logic               mode_ld,
  input logic               mode_val,
  input logic               compat_mode,
  input logic               sfr_rd,
  input logic               sfr_wr,
  input logic [7:0]         sfr_addr,
  input logic [1:0]         sfr_owner,
  input logic [1:0]         ram_sel,
  input logic [1:0]         ram_we
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ptr_q[0] == '0 && ptr_q[1] == '0 && !compat_mode));

  assert_direct_to_sfr_R2: assert property (@(posedge clk) disable iff (rst)
    (dir_rd || dir_wr) |-> (sfr_owner == 2'd1 && sfr_addr == dir_addr
                            && sfr_rd == dir_rd && sfr_wr == dir_wr));

  assert_flat_no_sfr_R3: assert property (@(posedge clk) disable iff (rst)
    (!compat_mode && !dir_rd && !dir_wr) |-> (sfr_owner == 2'd0 && !sfr_rd && !sfr_wr));

  assert_mode_load_R11: assert property (@(posedge clk) disable iff (rst)
    mode_ld |=> (compat_mode == $past(mode_val)));

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (rst)
    (sfr_owner == 2'd0) |-> (!sfr_rd && !sfr_wr));

  for (genvar g = 0; g < 2; g++) begin : g_chk
    assert_ptr_load_R6: assert property (@(posedge clk) disable iff (rst)
      ptr_ld[g] |=> (ptr_q[g] == $past(ptr_ld_val[g])));

    assert_flat_wrap_R5: assert property (@(posedge clk) disable iff (rst)
      (!compat_mode && !ptr_ld[g] && (ind_rd[g] || ind_wr[g]) && ind_inc[g])
      |=> (ptr_q[g] == $past(ptr_q[g]) + 1'b1));

    assert_compat_wrap_R9: assert property (@(posedge clk) disable iff (rst)
      (compat_mode && !ptr_ld[g] && (ind_rd[g] || ind_wr[g]) && ind_inc[g])
      |=> (ptr_q[g][7:0] == $past(ptr_q[g][7:0]) + 8'd1 && (ptr_q[g] >> 8) == '0));

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
      (!ptr_ld[g] && !ind_rd[g] && !ind_wr[g]) |=> $stable(ptr_q[g]));

    assert_we_in_sel_R12: assert property (@(posedge clk) disable iff (rst)
      ram_we[g] |-> (ram_sel[g] && ind_wr[g]));

    assert_flat_ram_R3: assert property (@(posedge clk) disable iff (rst)
      (!compat_mode && (ind_rd[g] || ind_wr[g])) |-> ram_sel[g]);
  end

endmodule

bind flatmem_mapper fm_checker #(.DEPTH(DEPTH), .SFR_SPAN(SFR_SPAN)) chk_i (.*);

// File: tb/flatmem_mapper_tb.sv
module flatmem_mapper_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 512;
  localparam int SPAN       = 32;
  localparam int AW         = $clog2(DEPTH);

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic               rst;
  logic               dir_rd, dir_wr;
  logic [7:0]         dir_addr, dir_wdata, dir_rdata;
  logic [1:0]         ind_rd, ind_wr, ind_inc;
  logic [1:0][7:0]    ind_wdata, ind_rdata;
  logic [1:0]         ptr_ld;
  logic [1:0][AW-1:0] ptr_ld_val, ptr_q;
  logic               mode_ld, mode_val, compat_mode;
  logic               sfr_rd, sfr_wr;
  logic [7:0]         sfr_addr, sfr_wdata, sfr_rdata;
  logic [1:0]         sfr_owner, ram_sel, ram_we;

  // external SFR space stand-in: data is a fixed function of the address
  assign sfr_rdata = sfr_addr ^ 8'hA5;

  flatmem_mapper #(.DEPTH(DEPTH), .SFR_SPAN(SPAN)) dut_i (.*);

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] m_mem [DEPTH];
  int m_ptr [2];
  bit m_mode;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    dir_rd = 0; dir_wr = 0; dir_addr = 0; dir_wdata = 0;
    ind_rd = 0; ind_wr = 0; ind_inc = 0; ind_wdata = '0;
    ptr_ld = 0; ptr_ld_val = '0; mode_ld = 0; mode_val = 0;
  endtask

  // compare this cycle against the model, then advance the model at the edge
  task automatic step(string tag);
    int a8 [2]; int idx [2]; bit acc [2]; bit hit [2];
    int own; int exp_addr; int exp_wd; bit exp_rd; bit exp_wr;
    #2;
    for (int i = 0; i < 2; i++) begin
      acc[i] = ind_rd[i] | ind_wr[i];
      a8[i]  = m_ptr[i] & 255;
      hit[i] = m_mode && (a8[i] < SPAN);
      idx[i] = m_mode ? a8[i] : m_ptr[i];
    end
    own = 0; exp_addr = 0; exp_wd = 0; exp_rd = 0; exp_wr = 0;
    if (dir_rd || dir_wr) begin
      own = 1; exp_addr = dir_addr; exp_wd = dir_wdata; exp_rd = dir_rd; exp_wr = dir_wr;
    end else begin
      for (int i = 1; i >= 0; i--)
        if (acc[i] && hit[i]) begin
          own = 2 + i; exp_addr = a8[i]; exp_wd = ind_wdata[i];
          exp_rd = ind_rd[i]; exp_wr = ind_wr[i];
        end
    end
    if (!rst) begin
      chk("R11", {tag, " mode"}, compat_mode, m_mode);
      chk("R10", {tag, " owner"}, sfr_owner, own);
      chk("R2", {tag, " sfr_rd"}, sfr_rd, exp_rd);
      chk("R2", {tag, " sfr_wr"}, sfr_wr, exp_wr);
      if (own != 0) begin
        chk("R8", {tag, " sfr_addr"}, sfr_addr, exp_addr);
        chk("R10", {tag, " sfr_wdata"}, sfr_wdata, exp_wd);
      end
      chk("R2", {tag, " dir_rdata"}, dir_rdata, dir_rd ? (exp_addr ^ 8'hA5) : 0);
      for (int i = 0; i < 2; i++) begin
        logic [7:0] er;
        chk(m_mode ? "R9" : "R5", $sformatf("%s ptr%0d", tag, i), ptr_q[i], m_ptr[i]);
        chk("R12", $sformatf("%s ram_sel%0d", tag, i), ram_sel[i], acc[i] && !hit[i]);
        chk("R12", $sformatf("%s ram_we%0d", tag, i), ram_we[i], ind_wr[i] && !hit[i]);
        if (!ind_rd[i])          er = 8'h00;
        else if (!hit[i])        er = m_mem[idx[i]];
        else if (own == 2 + i)   er = 8'(a8[i]) ^ 8'hA5;
        else                     er = 8'h00;
        if (^er !== 1'bx)
          chk(m_mode ? "R8" : "R4", $sformatf("%s rdata%0d", tag, i), ind_rdata[i], er);
      end
    end
    @(posedge clk);
    if (rst) begin
      m_ptr[0] = 0; m_ptr[1] = 0; m_mode = 0;
    end else begin
      for (int i = 1; i >= 0; i--)
        if (ind_wr[i] && !hit[i]) m_mem[idx[i]] = ind_wdata[i];
      for (int i = 0; i < 2; i++) begin
        if (ptr_ld[i])              m_ptr[i] = ptr_ld_val[i];
        else if (acc[i] && ind_inc[i])
          m_ptr[i] = m_mode ? ((a8[i] + 1) & 255) : ((m_ptr[i] + 1) % DEPTH);
      end
      if (mode_ld) m_mode = mode_val;
    end
    #1;
  endtask

  task automatic load_ptrs(int p0, int p1, string tag);
    idle(); ptr_ld = 2'b11; ptr_ld_val[0] = AW'(p0); ptr_ld_val[1] = AW'(p1);
    step(tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < DEPTH; k++) m_mem[k] = 'x;
    m_ptr[0] = 0; m_ptr[1] = 0; m_mode = 0;
    idle(); rst = 1;
    @(posedge clk); #1;
    step("reset"); step("reset");
    rst = 0;
    // R1: state right after reset
    chk("R1", "ptr0 after reset", ptr_q[0], 0);
    chk("R1", "ptr1 after reset", ptr_q[1], 0);
    chk("R1", "mode after reset", compat_mode, 0);
    step("R1 idle");

    // R2 direct accesses in flat mode
    idle(); dir_wr = 1; dir_addr = 8'h05; dir_wdata = 8'h3C; step("R2 dir write");
    idle(); dir_rd = 1; dir_addr = 8'h10; step("R2 dir read");

    // R6 pointer loads, R5 flat increment across the top of the array
    load_ptrs(DEPTH - 2, 16, "R6 load");
    for (int n = 0; n < 3; n++) begin
      idle(); ind_wr = 2'b11; ind_inc = 2'b11;
      ind_wdata[0] = 8'(8'h11 + n); ind_wdata[1] = 8'(8'h22 + n);
      step("R5 flat write wrap");
    end
    load_ptrs(DEPTH - 2, 16, "R6 reload");
    for (int n = 0; n < 3; n++) begin
      idle(); ind_rd = 2'b11; ind_inc = 2'b11; step("R4 flat read");
    end

    // R4 read and write of one entry in the same cycle
    load_ptrs(40, 40, "R6 same entry");
    idle(); ind_wr[0] = 1; ind_wdata[0] = 8'h77; step("R4 seed");
    idle(); ind_wr[0] = 1; ind_wdata[0] = 8'h88; ind_rd[1] = 1; step("R4 read old");
    idle(); ind_rd[1] = 1; step("R4 read new");

    // R7 same entry written by both ports
    idle(); ind_wr = 2'b11; ind_wdata[0] = 8'hAA; ind_wdata[1] = 8'hBB; step("R7 collide");
    idle(); ind_rd = 2'b11; step("R7 check");

    // R6 load wins over increment
    idle(); ind_rd[0] = 1; ind_inc[0] = 1; ptr_ld[0] = 1; ptr_ld_val[0] = AW'(300);
    step("R6 load over inc");
    idle(); step("R6 after");

    // R11 enter compatibility mode, R8 decode, R9 wrap
    idle(); mode_ld = 1; mode_val = 1; step("R11 set mode");
    load_ptrs(5, 9'h140, "R8 setup");
    idle(); ind_rd = 2'b11; step("R8 sfr and ram");
    idle(); ind_wr[1] = 1; ind_wdata[1] = 8'h5A; step("R8 ram write");
    idle(); ind_rd[1] = 1; step("R8 ram read");
    load_ptrs(DEPTH - 1, 255, "R9 setup");
    idle(); ind_rd = 2'b11; ind_inc = 2'b11; step("R9 wrap");
    idle(); dir_rd = 1; dir_addr = 8'hF0; step("R2 dir compat");

    // R10 arbitration
    load_ptrs(3, 4, "R10 setup");
    idle(); dir_rd = 1; dir_addr = 8'h08; ind_rd = 2'b11; step("R10 dir wins");
    idle(); ind_rd[0] = 1; ind_wr[1] = 1; ind_wdata[1] = 8'h66; step("R10 port0 wins");
    idle(); ind_rd[1] = 1; step("R10 port1 alone");

    // R3 back to flat mode, mixed random traffic
    idle(); mode_ld = 1; mode_val = 0; step("R3 flat again");
    for (int n = 0; n < 600; n++) begin
      idle();
      dir_rd = ($urandom_range(0, 7) == 0);
      dir_wr = !dir_rd && ($urandom_range(0, 9) == 0);
      dir_addr = 8'($urandom); dir_wdata = 8'($urandom);
      for (int i = 0; i < 2; i++) begin
        ind_rd[i] = $urandom_range(0, 2) == 0;
        ind_wr[i] = $urandom_range(0, 2) == 0;
        ind_inc[i] = (ind_rd[i] | ind_wr[i]) && $urandom_range(0, 1);
        ind_wdata[i] = 8'($urandom);
        ptr_ld[i] = $urandom_range(0, 15) == 0;
        ptr_ld_val[i] = AW'($urandom_range(0, 40) < 20 ? $urandom_range(0, 40) : $urandom);
      end
      mode_ld = $urandom_range(0, 31) == 0;
      mode_val = 1'($urandom);
      step("R3 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule